// File: doc/BRIEF.md
# Configurable Interrupt Source Capture

This block sits between 51 interrupt request lines and an interrupt controller's register bank. Every clock edge it samples each line and turns it into a raw pending bit. Three per-source configuration vectors set the rule for each bit. The mode vector picks level or edge detection. The both-edges vector picks whether an edge source reacts to one transition or to any transition. The polarity vector picks active-high/rising or active-low/falling.

A level source's pending bit simply mirrors its line, corrected for polarity. An edge source's pending bit is sticky. The line cannot lower it; only a clear mask from the register bank can. To find edges, the block keeps the previously sampled value of every line.

Only the polarity bits of the four highest sources can be rewritten at run time. All other configuration bits hold their reset values. Two vectors leave the block: the raw pending vector, and an edge-status vector that shows pending bits of edge-mode sources only.

Top module: `intsrc_capture`

## Requirements
- R1: After reset, raw_o and edge_stat_o are all zero and the previous-sample record is zero. The fixed configuration is mode = 0x1F07FFF8FFFF (bit set means level), both-edges = 0xF800070000 (bit set means any change) and polarity = 0x5F07FFF8FFFF (bit set means high/rising), where bit n belongs to source n.
- R2: For a level source, raw_o bit n equals the line sampled at the previous clock edge when its polarity bit is 1, and the inverted line when its polarity bit is 0.
- R3: For an edge source with its both-edges bit set, raw_o bit n becomes 1 one cycle after any sample that differs from the previous sample.
- R4: For a single-edge source, raw_o bit n is set by a 0-to-1 change when polarity is 1, and by a 1-to-0 change when polarity is 0. The opposite change and a steady line leave it unchanged, and the line never clears it.
- R5: A 1 in clr_mask_i bit n clears raw_o bit n on the next edge only when source n is in edge mode. Level sources ignore the mask.
- R6: The previous-sample record takes every new sample, whatever the mode. A line held steady after a clear therefore does not set the bit again.
- R7: When evt_wr_en is high at a clock edge, evt_wr_data bit k becomes the polarity of source 47+k. The new polarity governs samples from the next edge on. No other configuration bit can change.
- R8: edge_stat_o bit n equals raw_o bit n for edge-mode sources and is 0 for level sources.
- R9: When a qualifying edge and a clear for the same source arrive in the same cycle, raw_o bit n is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 51 | Interrupt request lines, synchronous to clk |
| clr_mask_i | input | 51 | One-cycle clear mask for edge-mode pending bits |
| evt_wr_en | input | 1 | Write strobe for the writable polarity bits |
| evt_wr_data | input | 4 | New polarity for sources 47 to 50 |
| raw_o | output | 51 | Raw pending vector |
| edge_stat_o | output | 51 | Pending bits of edge-mode sources |

## Verification
Each result is registered once, so a line value, a clear mask or a polarity write applied before rising edge k is reflected in raw_o and edge_stat_o after edge k. A polarity write changes detection only for samples taken at edge k+1 and later. The driver applies each stimulus on the falling edge and at the same moment queues the vectors expected after the next rising edge. The monitor pops and compares them 2 ns after that rising edge, which keeps every comparison exactly one register stage behind its stimulus. Internal reset release takes two cycles, and the bench waits longer than that before its first stimulus.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  localparam int unsigned INTSRC_N = 51;

  // Writable polarity window: the top four sources
  localparam int unsigned EVT_WR_LO = 47;
  localparam int unsigned EVT_WR_W  = 4;

  // Reset configuration, bit n belongs to source n
  localparam logic [63:0] MODE_RST64 = 64'h0000_1F07_FFF8_FFFF; // 1 = level
  localparam logic [63:0] BOTH_RST64 = 64'h0000_00F8_0007_0000; // 1 = any change
  localparam logic [63:0] POL_RST64  = 64'h0000_5F07_FFF8_FFFF; // 1 = high/rising

endpackage

// File: rtl/intsrc_rst_sync.sv
module intsrc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;

endmodule

// File: rtl/intsrc_cfg.sv
module intsrc_cfg #(
  parameter int unsigned NUM_SRC = 51,
  parameter int unsigned WR_LO   = 47,
  parameter int unsigned WR_W    = 4,
  parameter logic [NUM_SRC-1:0] MODE_RST = '0,
  parameter logic [NUM_SRC-1:0] BOTH_RST = '0,
  parameter logic [NUM_SRC-1:0] POL_RST  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WR_W-1:0]    wr_data,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] both_o,
  output logic [NUM_SRC-1:0] pol_o
);

  localparam int unsigned WR_HI = WR_LO + WR_W - 1;
  localparam logic [WR_W-1:0] WIN_RST = POL_RST[WR_HI:WR_LO];

  logic [WR_W-1:0] win_q;
  logic [WR_W-1:0] win_d;

  initial begin
    if (WR_HI >= NUM_SRC) $error("writable polarity window exceeds source count");
  end

  always_comb begin
    win_d = win_q;
    if (wr_en) win_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_RST;
    end else if (wr_en) begin
      win_q <= win_d;
    end
  end

  always_comb begin
    pol_o              = POL_RST;
    pol_o[WR_HI:WR_LO] = win_q;
  end

  assign mode_o = MODE_RST;
  assign both_o = BOTH_RST;

endmodule

// File: rtl/intsrc_lane.sv
module intsrc_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic level_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);

  logic prev_q;
  logic raw_q;
  logic raw_d;
  logic hit;
  logic raw_en;

  always_comb begin
    if (both_i) begin
      hit = smp_i ^ prev_q;
    end else if (pol_i) begin
      hit = smp_i & ~prev_q;
    end else begin
      hit = ~smp_i & prev_q;
    end

    if (level_i) begin
      raw_d = ~(smp_i ^ pol_i);
    end else begin
      raw_d = (raw_q & ~clr_i) | hit;
    end
    raw_en = raw_d ^ raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  assign raw_o = raw_q;

  // R2: level lanes track the polarity-corrected line
  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    level_i |=> raw_q == ($past(smp_i) ~^ $past(pol_i)));

  // R3: any change on a both-edges lane sets the bit
  a_r3_any_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && both_i && (smp_i != prev_q)) |=> raw_q);

  // R4: an edge lane's bit is sticky while not cleared
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && raw_q && !clr_i) |=> raw_q);

  // R5: clear on a steady edge lane empties the bit
  a_r5_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && clr_i && (smp_i == prev_q)) |=> !raw_q);

  // R6: previous sample always follows the line
  a_r6_prev_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(smp_i));

  // R9: a rising edge beats a simultaneous clear
  a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && !both_i && pol_i && smp_i && !prev_q && clr_i) |=> raw_q);

endmodule

// File: rtl/intsrc_capture.sv
module intsrc_capture
  import intsrc_pkg::*;
#(
  parameter int unsigned NUM_SRC = INTSRC_N,
  parameter int unsigned WR_LO   = EVT_WR_LO,
  parameter int unsigned WR_W    = EVT_WR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               evt_wr_en,
  input  logic [WR_W-1:0]    evt_wr_data,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] edge_stat_o
);

  localparam logic [NUM_SRC-1:0] MODE_RST = MODE_RST64[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] BOTH_RST = BOTH_RST64[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] POL_RST  = POL_RST64[NUM_SRC-1:0];

  logic               srst_n;
  logic [NUM_SRC-1:0] mode_v;
  logic [NUM_SRC-1:0] both_v;
  logic [NUM_SRC-1:0] pol_v;
  logic [NUM_SRC-1:0] raw_v;

  intsrc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  intsrc_cfg #(
    .NUM_SRC  (NUM_SRC),
    .WR_LO    (WR_LO),
    .WR_W     (WR_W),
    .MODE_RST (MODE_RST),
    .BOTH_RST (BOTH_RST),
    .POL_RST  (POL_RST)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (evt_wr_en),
    .wr_data (evt_wr_data),
    .mode_o  (mode_v),
    .both_o  (both_v),
    .pol_o   (pol_v)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    intsrc_lane u_lane (
      .clk     (clk),
      .rst_n   (srst_n),
      .smp_i   (src_i[g]),
      .level_i (mode_v[g]),
      .both_i  (both_v[g]),
      .pol_i   (pol_v[g]),
      .clr_i   (clr_mask_i[g]),
      .raw_o   (raw_v[g])
    );
  end

  assign raw_o       = raw_v;
  assign edge_stat_o = raw_v & ~mode_v;

  // R8: level sources never show in the edge-status vector
  a_r8_level_hidden: assert property (@(posedge clk) disable iff (!srst_n)
    (edge_stat_o & MODE_RST) == '0);

endmodule

// File: tb/tb_intsrc_capture.sv
module tb_intsrc_capture;

  localparam int N = 51;
  localparam logic [N-1:0] MODE_X = 51'h1F07FFF8FFFF;
  localparam logic [N-1:0] BOTH_X = 51'h00F800070000;
  localparam logic [N-1:0] POL_X  = 51'h5F07FFF8FFFF;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] src;
  logic [N-1:0] clr;
  logic         wr_en;
  logic [3:0]   wr_data;
  logic [N-1:0] raw;
  logic [N-1:0] estat;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [N-1:0] m_raw, m_prev, m_pol;
  logic [N-1:0] q_raw[$];
  logic [N-1:0] q_est[$];
  string        q_tag[$];

  intsrc_capture dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .clr_mask_i  (clr),
    .evt_wr_en   (wr_en),
    .evt_wr_data (wr_data),
    .raw_o       (raw),
    .edge_stat_o (estat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] b(int i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // Driver: apply one sample on the falling edge and queue the expectation
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] c,
                      input logic we, input logic [3:0] wd, input string tag);
    logic hit;
    @(negedge clk);
    src = s; clr = c; wr_en = we; wr_data = wd;
    for (int i = 0; i < N; i++) begin
      if (MODE_X[i]) begin
        m_raw[i] = (s[i] == m_pol[i]);
      end else begin
        if (BOTH_X[i])     hit = s[i] ^ m_prev[i];
        else if (m_pol[i]) hit = s[i] & ~m_prev[i];
        else               hit = ~s[i] & m_prev[i];
        m_raw[i] = (m_raw[i] & ~c[i]) | hit;
      end
    end
    m_prev = s;
    if (we) m_pol[50:47] = wd;
    q_raw.push_back(m_raw);
    q_est.push_back(m_raw & ~MODE_X);
    q_tag.push_back(tag);
  endtask

  task automatic st(input logic [N-1:0] s, input logic [N-1:0] c, input string tag);
    step(s, c, 1'b0, 4'h0, tag);
  endtask

  // Monitor: compare one register stage after each stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_raw.size() > 0) begin
        logic [N-1:0] er, ee;
        string t;
        er = q_raw.pop_front();
        ee = q_est.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (raw !== er || estat !== ee) begin
          errors++;
          $display("FAIL %s raw=%h edge=%h expected raw=%h edge=%h", t, raw, estat, er, ee);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; clr = '0; wr_en = 1'b0; wr_data = 4'h0;
    m_raw = '0; m_prev = '0; m_pol = POL_X;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (raw !== '0 || estat !== '0) begin
      errors++;
      $display("FAIL R1 reset raw=%h edge=%h expected raw=0 edge=0", raw, estat);
    end

    st(b(0), '0, "R2 level high line sets");
    st('0,   '0, "R2 level line low clears");
    st(b(16), '0, "R3 both-edges rise");
    st(b(16), '0, "R4 held high stays");
    st('0,   '0, "R3 both-edges fall keeps set");
    st('0,   b(16), "R5 clear edge source");
    st('0,   '0, "R6 steady line no re-set");
    st(b(46), '0, "R4 rising source sets");
    st(b(46), b(46), "R5 clear while held");
    st(b(46), '0, "R6 held after clear stays clear");
    st('0,   '0, "R4 falling on rising source ignored");
    st(b(45), '0, "R4 rise on falling source ignored");
    st('0,   '0, "R4 falling source sets");
    st('0,   b(45), "R5 clear falling source");
    st(b(0), '0, "R2 level set again");
    st(b(0), b(0), "R5 level ignores clear");
    st('0,   '0, "R2 level drops");
    st(b(46), b(46), "R9 edge beats clear");
    st(b(46), b(46), "R5 clear after edge");
    step('0, '0, 1'b1, 4'b0001, "R7 polarity write");
    st(b(47), '0, "R7 rewritten source now rising");
    st('0,   '0, "R7 fall ignored after write");
    st('0,   b(47), "R5 clear rewritten source");
    st(b(48), '0, "R7 unwritten bit 48 still falling");
    st('0,   '0, "R4 source 48 falling sets");
    st(b(35) | b(44), '0, "R8 edge status hides level 44");
    st(b(35), '0, "R3 both-edges 35 held");
    st('0, {N{1'b1}}, "R5 clear all edge sources");
    st('0, '0, "R1 quiet after clear");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule